// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block is a single-ported data cache for a processor with 32-bit byte addresses. It holds 256 lines of four 32-bit words. Each word address maps to exactly one line, taken from the low-order bits of its block address. Loads and stores that hit finish in the cycle they are presented. A miss raises a stall to the processor, and the stall stays up until the line has been brought in from the next memory level.

Stores that hit change only the cached copy and mark the line as modified. When a modified line is displaced, its four words are first copied out to memory, lowest word first, under the old tag. The new block is then fetched one word at a time. Store misses allocate a line: the full block is fetched first, and only then is the store word merged in, so a line never carries a new tag together with leftover words of the block it replaced. Only one miss is outstanding at any time.

The processor keeps its request, address and write data steady for as long as the stall is high. The memory side is a request/acknowledge word port. Each acknowledged cycle transfers one word: a write while the cache is evicting, and a read while it is refilling.

Top module: `wbdc_top`

## Requirements
- R1: The address splits as bits [1:0] byte (ignored), bits [3:2] word within line, bits [11:4] line index and bits [31:12] tag. Every memory-side address keeps the index of the access in bits [11:4]. It keeps bits [1:0] at zero and stays steady while a transfer waits for its acknowledge.
- R2: Reset marks every line invalid and unmodified, so the first access to any line is a miss.
- R3: A hit, read or write, drops no stall cycle. Read data for a hit is valid in the same cycle as the request.
- R4: A write hit updates only the cached word and marks the line modified. It makes no memory-side transfer.
- R5: A miss that displaces a modified line first writes the line's four words to memory, word 0 to word 3, at addresses built from the old tag and the same index.
- R6: A miss that displaces an invalid or unmodified line makes no memory write and goes straight to the refill.
- R7: A write miss fetches all four words of the new block and then merges the store word. The other three words of the line read back as memory's copy of the new block.
- R8: A read miss holds the stall high until the whole block is installed. Then, in the cycle the stall falls, it returns the requested word.
- R9: Miss handling steps through idle, writeback (only for a modified victim), refill, update and back to idle, in that order. No refill read comes before a writeback write of the same miss.
- R10: A completed refill leaves the line unmodified. A write miss sets the modified mark again in the update step, so a later displacement writes the line back.
- R11: When each memory word is acknowledged one cycle after it is requested, a miss on a clean or invalid line stalls for 9 cycles and a miss on a modified line stalls for 17 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the request is present and stall is low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory-side word transfer request |
| mem_we | output | 1 | 1 for a writeback word, 0 for a refill word |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Writeback word |
| mem_rdata | input | 32 | Refill word, valid with mem_ack |
| mem_ack | input | 1 | Completes the current word transfer |

## Verification
The assertions watch every cycle for the order of the miss states and for the victim being modified whenever a writeback runs. They also check that an installed line hits in the update step, that a fresh install reads back valid and unmodified, and that the memory address holds while a transfer waits. Only the bench's scenarios can show that the data is right. They compare every load against a flat reference memory, count the memory writes for clean and modified evictions, and read back memory's copy after index-conflict evictions. They confirm that a write miss leaves no stale words and measure the exact stall length of each kind of miss.

// File: rtl/wbdc_pkg.sv
package wbdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WB     = 2'd1,
        ST_REFILL = 2'd2,
        ST_UPDATE = 2'd3
    } wbdc_state_e;
endpackage

// File: rtl/wbdc_tags.sv
module wbdc_tags #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    output logic             lk_valid,
    output logic             lk_dirty,
    input  logic             inst_en,
    input  logic [TAG_W-1:0] inst_tag,
    input  logic             dirty_set
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q   [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (inst_en) tag_q[lk_idx] <= inst_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (inst_en) begin
            valid_q[lk_idx] <= 1'b1;
            dirty_q[lk_idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[lk_idx] <= 1'b1;
        end
    end

    assign lk_tag   = tag_q[lk_idx];
    assign lk_valid = valid_q[lk_idx];
    assign lk_dirty = dirty_q[lk_idx];

    // R10
    install_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inst_en) && lk_idx == $past(lk_idx)) |-> (lk_valid && !lk_dirty));
endmodule

// File: rtl/wbdc_data.sv
module wbdc_data #(
    parameter int IDX_W  = 8,
    parameter int WSEL_W = 2,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic [IDX_W+WSEL_W-1:0] rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    wr_en,
    input  logic [IDX_W+WSEL_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]       wr_data
);
    localparam int DEPTH = 1 << (IDX_W + WSEL_W);

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) words_q[wr_addr] <= wr_data;
    end

    assign rd_data = words_q[rd_addr];
endmodule

// File: rtl/wbdc_top.sv
module wbdc_top
    import wbdc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int BSEL_W = $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BSEL_W;
    localparam logic [WSEL_W-1:0] LAST_WORD = '1;

    typedef struct packed {
        wbdc_state_e       st;
        logic [WSEL_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]  cpu_idx;
    logic [WSEL_W-1:0] cpu_word;
    logic [TAG_W-1:0]  cpu_tag;
    logic              unused_bsel;

    assign cpu_idx     = cpu_addr[BSEL_W+WSEL_W +: IDX_W];
    assign cpu_word    = cpu_addr[BSEL_W +: WSEL_W];
    assign cpu_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_bsel = ^cpu_addr[BSEL_W-1:0];

    logic [TAG_W-1:0]        lk_tag;
    logic                    lk_valid, lk_dirty;
    logic                    inst_en, dirty_set, hit;
    logic [IDX_W+WSEL_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0]       rd_data, wr_data;
    logic                    wr_en;

    assign hit = lk_valid && (lk_tag == cpu_tag);

    always_comb begin
        ctl_d     = ctl_q;
        cpu_stall = 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        inst_en   = 1'b0;
        dirty_set = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = {cpu_idx, cpu_word};
        wr_data   = cpu_wdata;
        rd_addr   = {cpu_idx, cpu_word};
        mem_addr  = {cpu_tag, cpu_idx, ctl_q.cnt, {BSEL_W{1'b0}}};
        unique case (ctl_q.st)
            ST_IDLE: begin
                cpu_stall = cpu_req && !hit;
                if (cpu_req && hit && cpu_we) begin
                    wr_en     = 1'b1;
                    dirty_set = 1'b1;
                end
                if (cpu_req && !hit) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = (lk_valid && lk_dirty) ? ST_WB : ST_REFILL;
                end
            end
            ST_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                rd_addr  = {cpu_idx, ctl_q.cnt};
                mem_addr = {lk_tag, cpu_idx, ctl_q.cnt, {BSEL_W{1'b0}}};
                if (mem_ack) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_WORD) ctl_d.st = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    wr_en     = 1'b1;
                    wr_addr   = {cpu_idx, ctl_q.cnt};
                    wr_data   = mem_rdata;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_WORD) begin
                        inst_en  = 1'b1;
                        ctl_d.st = ST_UPDATE;
                    end
                end
            end
            ST_UPDATE: begin
                cpu_stall = 1'b0;
                if (cpu_req && cpu_we) begin
                    wr_en     = 1'b1;
                    dirty_set = 1'b1;
                end
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.cnt <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_rdata = rd_data;
    assign mem_wdata = rd_data;

    wbdc_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (cpu_idx),
        .lk_tag    (lk_tag),
        .lk_valid  (lk_valid),
        .lk_dirty  (lk_dirty),
        .inst_en   (inst_en),
        .inst_tag  (cpu_tag),
        .dirty_set (dirty_set)
    );

    wbdc_data #(.IDX_W(IDX_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // R9
    wb_to_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WB && mem_ack && ctl_q.cnt == LAST_WORD) |=> (ctl_q.st == ST_REFILL));
    // R9
    refill_to_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_REFILL && mem_ack && ctl_q.cnt == LAST_WORD) |=> (ctl_q.st == ST_UPDATE));
    // R9
    update_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_UPDATE) |=> (ctl_q.st == ST_IDLE));
    // R5
    wb_victim_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WB) |-> (lk_valid && lk_dirty));
    // R8
    update_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_UPDATE && cpu_req) |-> (hit && !cpu_stall));
    // R1
    mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/sim_wbdc_top.sv
module sim_wbdc_top;
    localparam int CLK_P = 10;
    localparam int LAT   = 1;
    localparam int LINES = 256;
    localparam int WORDS = 4;
    localparam int CLEAN_STALL = 1 + WORDS * (LAT + 1);
    localparam int DIRTY_STALL = 1 + 2 * WORDS * (LAT + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    int n_tests = 0, n_fail = 0;
    int memwr_n = 0, memrd_n = 0, addr_err = 0, order_err = 0;
    int exp_idx = 0;
    bit seen_read = 0;
    logic [31:0] backing [4096];
    logic [31:0] refm    [4096];

    always #(CLK_P/2) clk = ~clk;

    wbdc_top u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // next memory level: one wait cycle, then acknowledge
    initial begin
        int wcnt;
        wcnt = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req && wcnt == LAT) begin
                mem_ack = 1'b1;
                wcnt = 0;
                if (mem_addr[31:14] != 0 || int'(mem_addr[11:4]) != exp_idx || mem_addr[1:0] != 0)
                    addr_err++;
                if (mem_we) begin
                    if (seen_read) order_err++;
                    backing[mem_addr[13:2]] = mem_wdata;
                    memwr_n++;
                end else begin
                    seen_read = 1;
                    mem_rdata = backing[mem_addr[13:2]];
                    memrd_n++;
                end
            end else begin
                mem_ack = 1'b0;
                wcnt = mem_req ? wcnt + 1 : 0;
            end
        end
    end

    task automatic access(input bit we, input int tag, input int idx, input int w,
                          input logic [31:0] wd, input int exp_stall, input string req);
        int stalls;
        int widx;
        widx = tag * 1024 + idx * 4 + w;
        @(negedge clk);
        exp_idx = idx;
        seen_read = 0;
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = {12'(tag), 8'(idx), 2'(w), 2'b01};
        cpu_wdata = wd;
        stalls = 0;
        #1;
        while (cpu_stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        check(stalls == exp_stall, req, 32'(stalls), 32'(exp_stall));
        if (!we) check(cpu_rdata == refm[widx], req, cpu_rdata, refm[widx]);
        @(posedge clk);
        if (we) refm[widx] = wd;
        #1;
        cpu_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int wr0, rd0;
        for (int i = 0; i < 4096; i++) begin
            backing[i] = 32'(i) * 32'h0100_0193 + 32'h5a5a_0000;
            refm[i] = backing[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R2: idle after reset, no memory traffic
        check(!cpu_stall, "R2 reset stall", 32'(cpu_stall), 0);
        check(!mem_req, "R2 reset mem_req", 32'(mem_req), 0);

        // pass A: cold read sweep, R2 R8 R11 R3 R1 R6
        for (int i = 0; i < LINES; i++)
            for (int w = 0; w < WORDS; w++)
                access(0, 0, i, w, 0, (w == 0) ? CLEAN_STALL : 0, (w == 0) ? "R8 cold miss" : "R3 read hit");
        check(memwr_n == 0, "R6 no writeback on invalid", 32'(memwr_n), 0);
        check(memrd_n == LINES * WORDS, "R8 refill count", 32'(memrd_n), LINES * WORDS);

        // pass B: write hits, R4
        wr0 = memwr_n; rd0 = memrd_n;
        for (int i = 0; i < LINES; i++)
            access(1, 0, i, i % 4, 32'hC000_0000 + 32'(i), 0, "R4 write hit");
        check(memwr_n == wr0 && memrd_n == rd0, "R4 no memory traffic", 32'(memwr_n + memrd_n), 32'(wr0 + rd0));
        for (int i = 0; i < LINES; i += 37)
            access(0, 0, i, i % 4, 0, 0, "R4 write hit readback");

        // pass C: index conflicts evict dirty lines, R5 R9 R11
        for (int i = 0; i < LINES; i++) begin
            wr0 = memwr_n;
            access(0, 1, i, 0, 0, DIRTY_STALL, "R5 dirty eviction stall");
            check(memwr_n - wr0 == WORDS, "R5 writeback words", 32'(memwr_n - wr0), WORDS);
            check(backing[i * 4 + i % 4] == refm[i * 4 + i % 4], "R5 memory holds store",
                  backing[i * 4 + i % 4], refm[i * 4 + i % 4]);
        end
        check(order_err == 0, "R9 writeback before refill", 32'(order_err), 0);

        // pass D: write miss over clean lines, R7 R10 R6
        for (int i = 0; i < 16; i++) begin
            wr0 = memwr_n;
            access(1, 2, i, 2, 32'hD000_0000 + 32'(i), CLEAN_STALL, "R7 write miss stall");
            check(memwr_n == wr0, "R6 clean victim no write", 32'(memwr_n), 32'(wr0));
            for (int w = 0; w < WORDS; w++)
                access(0, 2, i, w, 0, 0, "R7 merged line readback");
        end

        // pass E: write-missed lines are dirty again, R10
        for (int i = 0; i < 16; i++) begin
            wr0 = memwr_n;
            access(0, 1, i, 3, 0, DIRTY_STALL, "R10 dirty after write miss");
            check(memwr_n - wr0 == WORDS, "R10 writeback words", 32'(memwr_n - wr0), WORDS);
            check(backing[2048 + i * 4 + 2] == refm[2048 + i * 4 + 2], "R10 memory holds store",
                  backing[2048 + i * 4 + 2], refm[2048 + i * 4 + 2]);
        end

        check(addr_err == 0, "R1 memory address fields", 32'(addr_err), 0);
        check(order_err == 0, "R9 transfer order", 32'(order_err), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule